// File: doc/BRIEF.md
# Five-Stream Programmable Alignment Delay

This block delays five parallel streams by a separately chosen number of clock cycles, from zero to seven. The five streams are two 12-bit pixel streams, a 12-bit alpha weight, a 1-bit number-format flag and a 2-bit rounding-mode code. It sits in front of a mixing datapath so that each operand and control can be skewed to line up with the others. The mixing arithmetic itself lies outside this block.

The five delay counts are held in one 15-bit setting word, made of five 3-bit fields. Software or a board controller writes this word one bit at a time, using a serial data bit and a slow load strobe. The strobe is brought into the clock domain by a two-flop synchronizer. Only its rising edge is acted on, so a strobe held high shifts exactly once. Each new bit enters at the top of the word and moves toward bit 0, so the first bit sent ends in bit 0.

A static bypass input overrides the word. While bypass is high, every stream passes with no added delay and the stored word is cleared.

Top module: `stream_align_delay`

## Requirements
- R1: After reset the setting word is zero, so every output equals its input in the same cycle.
- R2: The setting word's field map is fixed. Bits 2:0 set pixel A, bits 5:3 set pixel B, bits 8:6 set alpha, bits 11:9 set the format flag and bits 14:12 set the rounding code.
- R3: A field holding the unsigned value k (0 to 7) makes that output equal to the stream's input from k clock edges earlier. A value of 0 gives a combinational pass-through.
- R4: The setting word shifts only on a synchronized rising edge of the load strobe. On that edge it shifts right by one bit, and the serial bit enters bit 14. Holding the strobe high causes no further shift, and changing the serial bit while the strobe is low has no effect.
- R5: While bypass is high, all five outputs equal their inputs in the same cycle, and the stored word is cleared. After bypass drops, the delays stay at zero until the word is reloaded.
- R6: The five delays act independently. Each stream follows only its own field, whatever values the other fields hold.
- R7: The delay stages shift on every clock, whatever the setting. After the word changes, each output right away shows the input from its new delay count earlier, with no flush or refill period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low reset; clears the setting word and the delay stages |
| bypass | input | 1 | Static override: zero delay on all streams, and clears the word |
| cfg_bit | input | 1 | Serial setting data bit |
| cfg_strobe | input | 1 | Asynchronous load strobe; its rising edge shifts in cfg_bit |
| pix_a_in | input | 12 | Pixel stream A input |
| pix_b_in | input | 12 | Pixel stream B input |
| alpha_in | input | 12 | Alpha weight input |
| fmt_in | input | 1 | Number-format flag input |
| rnd_in | input | 2 | Rounding-mode code input |
| pix_a_out | output | 12 | Delayed pixel stream A |
| pix_b_out | output | 12 | Delayed pixel stream B |
| alpha_out | output | 12 | Delayed alpha weight |
| fmt_out | output | 1 | Delayed number-format flag |
| rnd_out | output | 2 | Delayed rounding-mode code |

## Verification
A stream value driven in one cycle is due at its output exactly k clock edges later, where k is that stream's field. With k equal to 0 it is due in the same cycle, before any edge. The bench drives new values just after each falling edge and samples one nanosecond later. It compares each output with an eight-deep history of what it drove, indexed by the field value in effect. A serial bit reaches the word on the third rising edge after the strobe rises, because it passes two synchronizer flops and then the edge detect. For this reason the bench stops comparing during a load and waits at least four edges after the last strobe before trusting the new word.

// File: rtl/sad_pkg.sv
package sad_pkg;
   localparam int unsigned SAD_PIX_W       = 12;
   localparam int unsigned SAD_ALPHA_W     = 12;
   localparam int unsigned SAD_FMT_W       = 1;
   localparam int unsigned SAD_RND_W       = 2;
   localparam int unsigned SAD_MAX_DELAY   = 7;
   localparam int unsigned SAD_FIELD_W     = 3;
   localparam int unsigned SAD_NUM_STREAMS = 5;
   localparam int unsigned SAD_WORD_W      = SAD_FIELD_W * SAD_NUM_STREAMS;

   // Field order inside the setting word; position is behaviour (R2)
   typedef enum int unsigned {
      ST_PIX_A = 0,
      ST_PIX_B = 1,
      ST_ALPHA = 2,
      ST_FMT   = 3,
      ST_RND   = 4
   } stream_e;
endpackage

// File: rtl/sad_strobe_sync.sv
module sad_strobe_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_raw,
   input  logic bit_raw,
   output logic strobe_rise,
   output logic bit_sync
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("sad_strobe_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] strobe_q;
   logic [SYNC_STAGES-1:0] bit_q;
   logic                   strobe_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q    <= '0;
         bit_q       <= '0;
         strobe_last <= 1'b0;
      end else begin
         strobe_q    <= {strobe_q[SYNC_STAGES-2:0], strobe_raw};
         bit_q       <= {bit_q[SYNC_STAGES-2:0], bit_raw};
         strobe_last <= strobe_q[SYNC_STAGES-1];
      end
   end

   assign strobe_rise = strobe_q[SYNC_STAGES-1] & ~strobe_last;
   assign bit_sync    = bit_q[SYNC_STAGES-1];

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_rise |=> !strobe_rise); // R4
endmodule

// File: rtl/sad_cfg_word.sv
module sad_cfg_word #(
   parameter int unsigned WORD_W = sad_pkg::SAD_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bypass,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [WORD_W-1:0] word
);
   if (WORD_W < 2) begin : g_bad_width
      $error("sad_cfg_word: WORD_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word <= '0;
      else if (bypass)    word <= '0;
      else if (shift_en)  word <= {shift_bit, word[WORD_W-1:1]};
   end

   AST_BYPASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (word == '0)); // R5
   AST_SHIFT_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !bypass) |=> (word[WORD_W-1] == $past(shift_bit))); // R4
   AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !bypass) |=> (word[WORD_W-2:0] == $past(word[WORD_W-1:1]))); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !bypass) |=> $stable(word)); // R4
endmodule

// File: rtl/sad_delay_line.sv
module sad_delay_line #(
   parameter int unsigned WIDTH     = 12,
   parameter int unsigned MAX_DELAY = 7,
   parameter int unsigned SEL_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   input  logic [SEL_W-1:0] sel,
   output logic [WIDTH-1:0] dout
);
   if (WIDTH < 1) begin : g_bad_width
      $error("sad_delay_line: WIDTH must be at least 1");
   end
   if (MAX_DELAY > (2 ** SEL_W) - 1) begin : g_bad_sel
      $error("sad_delay_line: SEL_W too narrow for MAX_DELAY");
   end

   if (MAX_DELAY == 0) begin : g_passthru
      logic unused_inputs;
      assign unused_inputs = clk ^ rst_n ^ (^sel);
      assign dout = din;
   end else begin : g_chain
      logic [WIDTH-1:0] stage [MAX_DELAY];
      logic             primed;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(MAX_DELAY); i++) stage[i] <= '0;
            primed <= 1'b0;
         end else begin
            stage[0] <= din;
            for (int i = 1; i < int'(MAX_DELAY); i++) stage[i] <= stage[i-1];
            primed <= 1'b1;
         end
      end

      always_comb begin
         dout = din;
         for (int k = 1; k <= int'(MAX_DELAY); k++) begin
            if (sel == SEL_W'(k)) dout = stage[k-1];
         end
      end

      AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && sel == SEL_W'(1)) |-> (dout == $past(din))); // R3
      AST_STAGES_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
         primed |-> (stage[0] == $past(din))); // R7
   end
endmodule

// File: rtl/stream_align_delay.sv
module stream_align_delay
   import sad_pkg::*;
#(
   parameter int unsigned PIX_W       = SAD_PIX_W,
   parameter int unsigned ALPHA_W     = SAD_ALPHA_W,
   parameter int unsigned FMT_W       = SAD_FMT_W,
   parameter int unsigned RND_W       = SAD_RND_W,
   parameter int unsigned MAX_DELAY   = SAD_MAX_DELAY,
   parameter int unsigned FIELD_W     = SAD_FIELD_W,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bypass,
   input  logic               cfg_bit,
   input  logic               cfg_strobe,
   input  logic [PIX_W-1:0]   pix_a_in,
   input  logic [PIX_W-1:0]   pix_b_in,
   input  logic [ALPHA_W-1:0] alpha_in,
   input  logic [FMT_W-1:0]   fmt_in,
   input  logic [RND_W-1:0]   rnd_in,
   output logic [PIX_W-1:0]   pix_a_out,
   output logic [PIX_W-1:0]   pix_b_out,
   output logic [ALPHA_W-1:0] alpha_out,
   output logic [FMT_W-1:0]   fmt_out,
   output logic [RND_W-1:0]   rnd_out
);
   localparam int unsigned NUM_ST = SAD_NUM_STREAMS;
   localparam int unsigned WORD_W = FIELD_W * NUM_ST;

   if (MAX_DELAY > (2 ** FIELD_W) - 1) begin : g_bad_field
      $error("stream_align_delay: FIELD_W cannot encode MAX_DELAY");
   end

   logic              load_rise;
   logic              load_bit;
   logic [WORD_W-1:0] cfg_word;
   logic [WORD_W-1:0] eff_word;
   logic [FIELD_W-1:0] tap_sel [NUM_ST];

   sad_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .strobe_raw(cfg_strobe), .bit_raw(cfg_bit),
      .strobe_rise(load_rise), .bit_sync(load_bit)
   );

   sad_cfg_word #(.WORD_W(WORD_W)) word_i (
      .clk(clk), .rst_n(rst_n), .bypass(bypass),
      .shift_en(load_rise), .shift_bit(load_bit), .word(cfg_word)
   );

   // Bypass takes effect in the same cycle; the register clears one edge later
   assign eff_word = bypass ? '0 : cfg_word;

   for (genvar s = 0; s < int'(NUM_ST); s++) begin : g_field
      assign tap_sel[s] = eff_word[s*FIELD_W +: FIELD_W];
   end

   sad_delay_line #(.WIDTH(PIX_W), .MAX_DELAY(MAX_DELAY), .SEL_W(FIELD_W)) dly_pix_a_i (
      .clk(clk), .rst_n(rst_n), .din(pix_a_in), .sel(tap_sel[ST_PIX_A]), .dout(pix_a_out));
   sad_delay_line #(.WIDTH(PIX_W), .MAX_DELAY(MAX_DELAY), .SEL_W(FIELD_W)) dly_pix_b_i (
      .clk(clk), .rst_n(rst_n), .din(pix_b_in), .sel(tap_sel[ST_PIX_B]), .dout(pix_b_out));
   sad_delay_line #(.WIDTH(ALPHA_W), .MAX_DELAY(MAX_DELAY), .SEL_W(FIELD_W)) dly_alpha_i (
      .clk(clk), .rst_n(rst_n), .din(alpha_in), .sel(tap_sel[ST_ALPHA]), .dout(alpha_out));
   sad_delay_line #(.WIDTH(FMT_W), .MAX_DELAY(MAX_DELAY), .SEL_W(FIELD_W)) dly_fmt_i (
      .clk(clk), .rst_n(rst_n), .din(fmt_in), .sel(tap_sel[ST_FMT]), .dout(fmt_out));
   sad_delay_line #(.WIDTH(RND_W), .MAX_DELAY(MAX_DELAY), .SEL_W(FIELD_W)) dly_rnd_i (
      .clk(clk), .rst_n(rst_n), .din(rnd_in), .sel(tap_sel[ST_RND]), .dout(rnd_out));

   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (pix_a_out == pix_a_in && pix_b_out == pix_b_in &&
                  alpha_out == alpha_in && fmt_out == fmt_in && rnd_out == rnd_in)); // R5
   AST_BYPASS_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bypass) && !load_rise) |=> (cfg_word == '0)); // R5
endmodule

// File: tb/stream_align_delay_tb.sv
`timescale 1ns/1ps
module stream_align_delay_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bypass = 1'b0;
   logic        cfg_bit = 1'b0;
   logic        cfg_strobe = 1'b0;
   logic [11:0] pix_a_in = '0, pix_b_in = '0, alpha_in = '0;
   logic [0:0]  fmt_in = '0;
   logic [1:0]  rnd_in = '0;
   logic [11:0] pix_a_out, pix_b_out, alpha_out;
   logic [0:0]  fmt_out;
   logic [1:0]  rnd_out;

   always #2.5 clk = ~clk;

   stream_align_delay dut_i (
      .clk(clk), .rst_n(rst_n), .bypass(bypass), .cfg_bit(cfg_bit), .cfg_strobe(cfg_strobe),
      .pix_a_in(pix_a_in), .pix_b_in(pix_b_in), .alpha_in(alpha_in), .fmt_in(fmt_in),
      .rnd_in(rnd_in), .pix_a_out(pix_a_out), .pix_b_out(pix_b_out), .alpha_out(alpha_out),
      .fmt_out(fmt_out), .rnd_out(rnd_out));

   int          vectors = 0;
   int          misses = 0;
   bit          streaming = 0;
   bit          checking = 0;
   string       cur_req = "R1";
   logic [14:0] model_word = '0;
   logic [11:0] hist [5][8];

   initial begin
      for (int s = 0; s < 5; s++)
         for (int i = 0; i < 8; i++) hist[s][i] = '0;
   end

   function automatic int field_of(input logic [14:0] w, input logic byp, input int s);
      if (byp) return 0;
      return int'(w[s*3 +: 3]);
   endfunction

   function automatic logic [14:0] pack_word(input int a, input int b, input int al,
                                              input int f, input int r);
      return {3'(r), 3'(f), 3'(al), 3'(b), 3'(a)};
   endfunction

   task automatic compare(input int s, input logic [11:0] got, input logic [11:0] mask);
      logic [11:0] exp;
      exp = hist[s][field_of(model_word, bypass, s)] & mask;
      vectors++;
      if ((got & mask) !== exp) begin
         misses++;
         $display("FAIL %s stream %0d: got %h expected %h (word %h bypass %0b)",
                  cur_req, s, got & mask, exp, model_word, bypass);
      end
   endtask

   // Drive just after the falling edge, sample 1 ns later
   always @(negedge clk) begin
      if (streaming) begin
         for (int s = 0; s < 5; s++) begin
            for (int i = 7; i > 0; i--) hist[s][i] = hist[s][i-1];
            hist[s][0] = 12'($urandom);
         end
         hist[3][0] &= 12'h001;
         hist[4][0] &= 12'h003;
         pix_a_in = hist[0][0];
         pix_b_in = hist[1][0];
         alpha_in = hist[2][0];
         fmt_in   = hist[3][0][0:0];
         rnd_in   = hist[4][0][1:0];
         #1;
         if (checking) begin
            compare(0, pix_a_out, 12'hFFF);
            compare(1, pix_b_out, 12'hFFF);
            compare(2, alpha_out, 12'hFFF);
            compare(3, {11'b0, fmt_out}, 12'h001);
            compare(4, {10'b0, rnd_out}, 12'h003);
         end
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_word(input logic [14:0] w, input int hold);
      checking = 0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         cfg_bit = w[i];
         run(2);
         cfg_strobe = 1'b1;
         run(hold);
         cfg_strobe = 1'b0;
         run(3);
      end
      run(2);
      model_word = w;
   endtask

   initial begin
      void'($urandom(32'h5A17_0C3E));
      run(4);
      rst_n = 1'b1;
      // R1: zero word after reset, pass-through
      cur_req = "R1";
      streaming = 1; checking = 1;
      run(20);

      // R2: directed field map, distinct delays per stream
      load_word(pack_word(1, 4, 7, 0, 2), 4);
      cur_req = "R7"; checking = 1; run(2);   // R7: no flush right after the change
      cur_req = "R2"; run(40);

      // R3: every delay count 0..7 on all fields
      for (int k = 0; k < 8; k++) begin
         load_word(pack_word(k, k, k, k, k), 3);
         cur_req = "R3"; checking = 1; run(20);
      end

      // R6: random independent settings
      for (int n = 0; n < 6; n++) begin
         load_word(15'($urandom), 3 + n);
         cur_req = "R6"; checking = 1; run(25);
      end

      // R4: long strobe hold shifts once per edge only
      load_word(pack_word(6, 2, 5, 7, 3), 12);
      cur_req = "R4"; checking = 1; run(20);
      // R4: serial bit wiggling with strobe low leaves the word alone
      for (int n = 0; n < 30; n++) begin
         cfg_bit = ~cfg_bit;
         run(1);
      end
      run(20);

      // R5: bypass forces zero delay, and clears the word
      cur_req = "R5";
      bypass = 1'b1;
      run(30);
      bypass = 1'b0;
      model_word = '0;
      run(30);

      checking = 0; streaming = 0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule